// File: doc/BRIEF.md
# T1 Framing Loss Monitor with Host Reframe

This block watches the terminal framing bits of a received T1 stream once frame alignment has been acquired. For every framing-bit position an upstream comparator tells the block whether the received bit matched the expected alternating pattern. The block keeps a short history of those match results and declares loss of synchronisation when the error density inside a sliding window crosses a limit. The window and limit come from a mode select: a tolerant maintenance setting or a stricter normal setting.

Independently of the error check, the host can force a new frame search. It does this by raising a reframe control bit, holding it across at least one complete frame, and then lowering it. Only that high-to-low transition, after a qualifying high period, starts a search; a bit that stays low, or a short blip, does nothing. In both cases the block emits a single-cycle search-restart pulse to the external frame search logic, drops its in-sync output and wipes its error history. It regains sync only when the search logic reports that alignment has been found.

Top module: `t1_sync_monitor`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), in_sync, sync_lost and search_restart are all 0.
- R2: While out of sync, an align_found pulse sets in_sync to 1 at the following clock edge.
- R3: With maint_mode = 0, a framing error (ft_strobe = 1 with ft_match = 0) causes loss of sync when the newest 4 framing samples, counting this one, hold 2 or more errors. A single error among the newest 4 does not cause loss.
- R4: With maint_mode = 1, loss of sync occurs when the newest 12 framing samples, counting this one, hold 4 or more errors. Three errors within 12 samples do not cause loss, even when they are adjacent.
- R5: On loss of sync, sync_lost and search_restart are both 1 for exactly one cycle, starting one clock after the offending strobe, and in_sync becomes 0 in that same cycle.
- R6: The error history is emptied on every loss of sync and every reframe, so errors seen before resync never count afterwards.
- R7: ft_match is sampled only in cycles where ft_strobe = 1 and in_sync = 1. Between strobes, and while out of sync, the history holds and no loss can be declared.
- R8: When reframe_ctl falls after at least 2 frame_strobe pulses were seen while it was high (so that a whole frame lies inside the high time), search_restart is 1 for one cycle, one clock after the falling edge. In the same cycle in_sync becomes 0 while sync_lost stays 0.
- R9: A reframe_ctl high period with fewer than 2 frame strobes, or a steady low level, produces no search_restart. The frame count starts again from zero on every new high period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ft_strobe | input | 1 | One-cycle strobe at each terminal framing-bit position |
| ft_match | input | 1 | 1 when the framing bit at this strobe matched the expected pattern |
| frame_strobe | input | 1 | One-cycle strobe per received frame |
| maint_mode | input | 1 | 1 selects the 4-in-12 limit, 0 selects the 2-in-4 limit |
| reframe_ctl | input | 1 | Host reframe control bit, acted on at its falling edge |
| align_found | input | 1 | Pulse from the frame search logic when alignment is found |
| in_sync | output | 1 | 1 while frame alignment is held |
| sync_lost | output | 1 | One-cycle pulse when the error limit is crossed |
| search_restart | output | 1 | One-cycle pulse asking the frame search logic to start over |

## Verification
The embedded properties check on every cycle that a loss pulse only follows an errored framing strobe taken while in sync. They also check that every loss or restart drops in_sync with one-cycle pulses, that a reframe restart follows a falling edge of the control bit, that resync follows align_found, and that the history clears and holds as intended. The directed scenarios are needed for the threshold boundaries in each mode: one error versus two in four, three spread or adjacent errors versus four in twelve. They are also needed to show that the history is wiped, and to tell a qualifying reframe apart from a short pulse, a steady low level or a count carried over between high periods.

// File: rtl/t1sm_pkg.sv
// Package: shared helpers for the T1 framing loss monitor.
// Assumes callers pass window spans no wider than 32 samples.
package t1sm_pkg;

    // Counts set bits among the lowest `span` bits of a history word.
    function automatic int unsigned count_low_ones(input logic [31:0] word,
                                                   input int unsigned span);
        int unsigned total;
        total = 0;
        for (int unsigned i = 0; i < 32; i++) begin
            if (i < span && word[i]) total++;
        end
        return total;
    endfunction

endpackage

// File: rtl/ft_error_window.sv
// Module: ft_error_window
// Keeps a shift-register history of framing errors (1 = errored sample,
// newest in bit 0) and flags, in the same cycle as a sample, whether the
// window including that sample reaches the selected error limit.
// Assumes MAINT_SPAN and NORM_SPAN do not exceed HIST_LEN (<= 32).
module ft_error_window #(
    parameter int unsigned HIST_LEN    = 12,
    parameter int unsigned NORM_SPAN   = 4,
    parameter int unsigned NORM_LIMIT  = 2,
    parameter int unsigned MAINT_SPAN  = 12,
    parameter int unsigned MAINT_LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_en,
    input  logic sample_err,
    input  logic clear,
    input  logic maint_sel,
    output logic loss_now
);
    import t1sm_pkg::*;

    logic [HIST_LEN-1:0] hist;
    logic [HIST_LEN-1:0] next_win;
    logic [31:0]         next_wide;
    int unsigned         norm_cnt;
    int unsigned         maint_cnt;

    // Candidate window: history shifted with the current sample entering.
    assign next_win  = {hist[HIST_LEN-2:0], sample_err};
    assign next_wide = 32'(next_win);

    // Error counts over the two spans and the limit decision.
    always_comb begin
        norm_cnt  = count_low_ones(next_wide, NORM_SPAN);
        maint_cnt = count_low_ones(next_wide, MAINT_SPAN);
        if (maint_sel) loss_now = sample_en && (maint_cnt >= MAINT_LIMIT);
        else           loss_now = sample_en && (norm_cnt >= NORM_LIMIT);
    end

    // History register: clear wins, otherwise shift only on a sample.
    always_ff @(posedge clk) begin
        if (!rst_n)         hist <= '0;
        else if (clear)     hist <= '0;
        else if (sample_en) hist <= next_win;
    end

    assert_hist_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (hist == '0));

    assert_hist_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_en && !clear) |=> $stable(hist));

endmodule

// File: rtl/reframe_detector.sv
// Module: reframe_detector
// Qualifies the host reframe bit: counts frame strobes while the bit is
// high and flags a request on the falling edge once NEED strobes were seen,
// which places at least MIN_FRAMES whole frames inside the high period.
// Assumes frame_strobe is a single-cycle pulse once per frame.
module reframe_detector #(
    parameter int unsigned MIN_FRAMES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl,
    input  logic frame_strobe,
    output logic go
);
    localparam int unsigned NEED = MIN_FRAMES + 1;
    localparam int unsigned CW   = $clog2(NEED + 1);

    logic          ctl_q;
    logic [CW-1:0] frame_cnt;

    // Falling edge with a qualified high period.
    assign go = ctl_q && !ctl && (frame_cnt == CW'(NEED));

    // Previous control level, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= 1'b0;
        else        ctl_q <= ctl;
    end

    // Saturating frame counter, restarted whenever the bit is low.
    always_ff @(posedge clk) begin
        if (!rst_n)                                       frame_cnt <= '0;
        else if (!ctl)                                    frame_cnt <= '0;
        else if (frame_strobe && frame_cnt != CW'(NEED))  frame_cnt <= frame_cnt + 1'b1;
    end

    assert_go_needs_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> ($past(ctl) && !ctl));

endmodule

// File: rtl/t1_sync_monitor.sv
// Module: t1_sync_monitor (top)
// Tracks frame sync after alignment: counts framing errors in a mode-
// selected sliding window, honours the host reframe bit, and drives the
// in-sync flag plus one-cycle loss and search-restart pulses.
// Assumes an upstream comparator supplies ft_match at each ft_strobe and
// that the external search logic pulses align_found on alignment.
module t1_sync_monitor #(
    parameter int unsigned HIST_LEN    = 12,
    parameter int unsigned NORM_SPAN   = 4,
    parameter int unsigned NORM_LIMIT  = 2,
    parameter int unsigned MAINT_SPAN  = 12,
    parameter int unsigned MAINT_LIMIT = 4,
    parameter int unsigned MIN_FRAMES  = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ft_strobe,
    input  logic ft_match,
    input  logic frame_strobe,
    input  logic maint_mode,
    input  logic reframe_ctl,
    input  logic align_found,
    output logic in_sync,
    output logic sync_lost,
    output logic search_restart
);
    logic sample_en;
    logic loss_now;
    logic reframe_go;
    logic restart_now;

    assign sample_en   = ft_strobe && in_sync;
    assign restart_now = loss_now || reframe_go;

    ft_error_window #(
        .HIST_LEN   (HIST_LEN),
        .NORM_SPAN  (NORM_SPAN),
        .NORM_LIMIT (NORM_LIMIT),
        .MAINT_SPAN (MAINT_SPAN),
        .MAINT_LIMIT(MAINT_LIMIT)
    ) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .sample_err(!ft_match),
        .clear     (restart_now),
        .maint_sel (maint_mode),
        .loss_now  (loss_now)
    );

    reframe_detector #(
        .MIN_FRAMES(MIN_FRAMES)
    ) u_reframe (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl         (reframe_ctl),
        .frame_strobe(frame_strobe),
        .go          (reframe_go)
    );

    // Sync state and one-cycle output pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_sync        <= 1'b0;
            sync_lost      <= 1'b0;
            search_restart <= 1'b0;
        end else begin
            sync_lost      <= loss_now;
            search_restart <= restart_now;
            if (restart_now)      in_sync <= 1'b0;
            else if (align_found) in_sync <= 1'b1;
        end
    end

    assert_loss_after_error_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sync_lost |-> ($past(ft_strobe) && !$past(ft_match) && $past(in_sync)));

    assert_loss_drops_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sync_lost |-> (search_restart && !in_sync));

    assert_restart_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        search_restart |=> !search_restart);

    assert_reframe_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (search_restart && !sync_lost) |-> (!$past(reframe_ctl) && $past(reframe_ctl, 2)));

    assert_resync_needs_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_sync) |-> $past(align_found));

endmodule

// File: tb/tb_t1_sync_monitor.sv
// Directed bench for t1_sync_monitor: inputs change on falling edges,
// outputs are sampled on falling edges after the registering rising edge.
module tb_t1_sync_monitor;
    logic clk = 1'b0;
    logic rst_n, ft_strobe, ft_match, frame_strobe, maint_mode;
    logic reframe_ctl, align_found;
    logic in_sync, sync_lost, search_restart;
    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;

    always #4 clk = ~clk;

    t1_sync_monitor dut (
        .clk(clk), .rst_n(rst_n), .ft_strobe(ft_strobe), .ft_match(ft_match),
        .frame_strobe(frame_strobe), .maint_mode(maint_mode),
        .reframe_ctl(reframe_ctl), .align_found(align_found),
        .in_sync(in_sync), .sync_lost(sync_lost), .search_restart(search_restart)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ft(input bit m);
        ft_strobe = 1'b1; ft_match = m;
        @(negedge clk);
        ft_strobe = 1'b0; ft_match = 1'b1;
    endtask

    task automatic acquire();
        align_found = 1'b1;
        @(negedge clk);
        align_found = 1'b0;
    endtask

    task automatic frame_tick();
        frame_strobe = 1'b1;
        @(negedge clk);
        frame_strobe = 1'b0;
        idle(3);
    endtask

    task automatic expect_loss(input string tag);
        chk({tag, " sync_lost"}, sync_lost, 1);
        chk({tag, " restart"}, search_restart, 1);
        chk({tag, " in_sync"}, in_sync, 0);
        idle(1);
        chk({tag, " sync_lost width R5"}, sync_lost, 0);
        chk({tag, " restart width R5"}, search_restart, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; ft_strobe = 0; ft_match = 1; frame_strobe = 0;
        maint_mode = 0; reframe_ctl = 0; align_found = 0;
        idle(3);
        rst_n = 1'b1;
        chk("R1 in_sync", in_sync, 0);
        chk("R1 sync_lost", sync_lost, 0);
        chk("R1 restart", search_restart, 0);
        ft(0); ft(0); ft(0);
        chk("R7 no loss while out of sync", sync_lost, 0);
    endtask

    task automatic t_acquire();
        acquire();
        chk("R2 in_sync after align", in_sync, 1);
    endtask

    task automatic t_normal();
        maint_mode = 0;
        ft(0); ft(1); ft(1); ft(1); ft(0);
        chk("R3 one error in four", in_sync, 1);
        ft(1);
        chk("R3 still one error", sync_lost, 0);
        ft(0);
        expect_loss("R3 two errors in four R5");
    endtask

    task automatic t_clear_hold();
        acquire();
        ft(0);
        chk("R6 history cleared on loss", in_sync, 1);
        ft(1); ft(1); ft(1);
        ft_match = 1'b0;
        idle(10);
        ft_match = 1'b1;
        chk("R7 mismatch without strobe", in_sync, 1);
        ft(0);
        chk("R7 unstrobed mismatches not counted", in_sync, 1);
        ft(0);
        expect_loss("R3 adjacent errors");
    endtask

    task automatic t_maint();
        maint_mode = 1;
        acquire();
        ft(0); ft(0); ft(0);
        chk("R4 three adjacent errors", in_sync, 1);
        ft(0);
        expect_loss("R4 four errors");
        acquire();
        for (int i = 1; i <= 13; i++) ft((i % 4) != 1);
        chk("R4 three spread errors in twelve", in_sync, 1);
        ft(0);
        expect_loss("R4 fourth error in twelve");
        maint_mode = 0;
    endtask

    task automatic t_reframe();
        acquire();
        reframe_ctl = 1'b1;
        frame_tick(); frame_tick();
        chk("R8 no restart while high", search_restart, 0);
        reframe_ctl = 1'b0;
        @(negedge clk);
        chk("R8 restart after fall", search_restart, 1);
        chk("R8 in_sync dropped", in_sync, 0);
        chk("R8 no sync_lost", sync_lost, 0);
        idle(1);
        chk("R8 restart width", search_restart, 0);
        acquire();
        ft(0);
        chk("R6 history cleared on reframe", in_sync, 1);
    endtask

    task automatic t_reframe_reject();
        acquire();
        reframe_ctl = 1'b1;
        frame_tick();
        reframe_ctl = 1'b0;
        @(negedge clk);
        chk("R9 short pulse restart", search_restart, 0);
        chk("R9 short pulse in_sync", in_sync, 1);
        reframe_ctl = 1'b1;
        frame_tick();
        reframe_ctl = 1'b0;
        @(negedge clk);
        chk("R9 count restarts per high period", search_restart, 0);
        for (int i = 0; i < 5; i++) frame_tick();
        chk("R9 steady low restart", search_restart, 0);
        chk("R9 steady low in_sync", in_sync, 1);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_acquire();
        t_normal();
        t_clear_hold();
        t_maint();
        t_reframe();
        t_reframe_reject();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule